// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block gives the execute stage of a five-stage in-order pipeline the correct value for each of its two source operands. The register file is only written during write-back, the last stage. So a result produced by one of the three instructions ahead of the consumer may still be in flight when the consumer enters execute. The block compares each execute-stage source register number with the destination of three producers:

- the instruction now in the memory stage (distance one);
- the instruction now in write-back (distance two);
- the instruction that completed write-back one cycle earlier (distance three).

A producer counts only when its write enable is set. For each operand the block then picks the newest matching value, or the register-file read value when nothing matches.

Distance three is covered by a small internal latch. It records the write-back port for one cycle, so the result is correct whatever the register file's read/write ordering. A producer in the memory stage that is a load has no data yet. It is never bypassed from there. Holding the consumer back for that case is handled outside this block.

Top module: `opnd_bypass`

## Requirements
- R1: With no qualifying producer, each operand equals its register-file read value and its select output is 0 (register file).
- R2: A memory-stage producer that is not a load, has its write enable set and has a destination equal to the operand's source supplies that operand (select 1).
- R3: A qualifying write-back-stage producer whose destination matches, with no qualifying memory-stage match, supplies the operand (select 2).
- R4: A register write presented on the write-back port in the previous cycle supplies a matching operand when neither newer stage matches (select 3). This covers a consumer three instructions after its producer.
- R5: When several producers match, the nearest one wins: memory stage over write-back stage over the previous-cycle write.
- R6: Source register 0 is never bypassed; it always takes the register-file value with select 0.
- R7: A producer whose write enable is low never matches, whatever its destination and value.
- R8: A memory-stage producer flagged as a load is ignored; the operand falls back to the older producers or the register file.
- R9: The two operands are selected independently and may take different sources in the same cycle.
- R10: Reset clears the previous-cycle write latch, so right after reset no operand uses select 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ex_src_a | input | REGW | Source register number of operand A in execute |
| ex_src_b | input | REGW | Source register number of operand B in execute |
| rf_val_a | input | XLEN | Register-file read value for operand A |
| rf_val_b | input | XLEN | Register-file read value for operand B |
| mem_rd | input | REGW | Destination register of the memory-stage instruction |
| mem_we | input | 1 | Register-write enable of the memory-stage instruction |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_val | input | XLEN | ALU result held in the memory stage |
| wb_rd | input | REGW | Destination register being written back |
| wb_we | input | 1 | Write-back register-write enable |
| wb_val | input | XLEN | Value being written back |
| op_a | output | XLEN | Selected value of operand A |
| op_b | output | XLEN | Selected value of operand B |
| sel_a | output | 2 | Source chosen for A: 0 regfile, 1 memory, 2 write-back, 3 previous write |
| sel_b | output | 2 | Source chosen for B, same encoding |

## Verification
The assertions take for granted that reset is held low for at least one clock edge before use. They also assume that the write-back port carries exactly what the register file receives, since the check on select 3 relates it to the previous cycle's write-back inputs. The stimulus drives every input right after the falling edge and holds write-back values steady across the rising edge the latch samples. Each scenario task sets all producer fields explicitly, so no leftover enable from an earlier scenario creates an unplanned match.

// File: rtl/opnd_bypass_pkg.sv
package opnd_bypass_pkg;

    // Operand source select; the numbering is exposed on sel_a / sel_b.
    typedef enum logic [1:0] {
        SRC_RF   = 2'd0,
        SRC_MEM  = 2'd1,
        SRC_WB   = 2'd2,
        SRC_PREV = 2'd3
    } src_sel_e;

endpackage

// File: rtl/bypass_prev_latch.sv
// Holds the register write seen on the write-back port one cycle ago.
module bypass_prev_latch #(
    parameter int XLEN = 32,
    parameter int REGW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [REGW-1:0] wb_rd,
    input  logic            wb_we,
    input  logic [XLEN-1:0] wb_val,
    output logic [REGW-1:0] prev_rd,
    output logic            prev_we,
    output logic [XLEN-1:0] prev_val
);

    typedef struct packed {
        logic            we;
        logic [REGW-1:0] rd;
        logic [XLEN-1:0] val;
    } prev_t;

    prev_t prev_d;
    prev_t prev_q;

    always_comb begin
        prev_d = prev_q;
        if (!rst_n) begin
            prev_d = '0;
        end else begin
            prev_d.we  = wb_we;
            prev_d.rd  = wb_rd;
            prev_d.val = wb_val;
        end
    end

    always_ff @(posedge clk) begin
        prev_q <= prev_d;
    end

    assign prev_rd  = prev_q.rd;
    assign prev_we  = prev_q.we;
    assign prev_val = prev_q.val;

endmodule

// File: rtl/bypass_pick.sv
// Match and priority for one source operand.
module bypass_pick
    import opnd_bypass_pkg::*;
#(
    parameter int REGW = 5
) (
    input  logic [REGW-1:0] src,
    input  logic [REGW-1:0] mem_rd,
    input  logic            mem_we,
    input  logic            mem_is_load,
    input  logic [REGW-1:0] wb_rd,
    input  logic            wb_we,
    input  logic [REGW-1:0] prev_rd,
    input  logic            prev_we,
    output src_sel_e        sel
);

    logic src_live;
    logic hit_mem;
    logic hit_wb;
    logic hit_prev;

    always_comb begin
        src_live = (src != '0);
        hit_mem  = src_live && mem_we && !mem_is_load && (mem_rd == src);
        hit_wb   = src_live && wb_we && (wb_rd == src);
        hit_prev = src_live && prev_we && (prev_rd == src);
        if (hit_mem) begin
            sel = SRC_MEM;
        end else if (hit_wb) begin
            sel = SRC_WB;
        end else if (hit_prev) begin
            sel = SRC_PREV;
        end else begin
            sel = SRC_RF;
        end
    end

endmodule

// File: rtl/bypass_mux.sv
// Four-way operand mux driven by the select.
module bypass_mux
    import opnd_bypass_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  src_sel_e        sel,
    input  logic [XLEN-1:0] rf_val,
    input  logic [XLEN-1:0] mem_val,
    input  logic [XLEN-1:0] wb_val,
    input  logic [XLEN-1:0] prev_val,
    output logic [XLEN-1:0] op
);

    always_comb begin
        unique case (sel)
            SRC_MEM:  op = mem_val;
            SRC_WB:   op = wb_val;
            SRC_PREV: op = prev_val;
            default:  op = rf_val;
        endcase
    end

endmodule

// File: rtl/opnd_bypass.sv
module opnd_bypass
    import opnd_bypass_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int REGW = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [REGW-1:0] ex_src_a,
    input  logic [REGW-1:0] ex_src_b,
    input  logic [XLEN-1:0] rf_val_a,
    input  logic [XLEN-1:0] rf_val_b,
    input  logic [REGW-1:0] mem_rd,
    input  logic            mem_we,
    input  logic            mem_is_load,
    input  logic [XLEN-1:0] mem_val,
    input  logic [REGW-1:0] wb_rd,
    input  logic            wb_we,
    input  logic [XLEN-1:0] wb_val,
    output logic [XLEN-1:0] op_a,
    output logic [XLEN-1:0] op_b,
    output logic [1:0]      sel_a,
    output logic [1:0]      sel_b
);

    localparam int NOPS = 2;

    logic [REGW-1:0] prev_rd;
    logic            prev_we;
    logic [XLEN-1:0] prev_val;

    logic [REGW-1:0] src_v [NOPS];
    logic [XLEN-1:0] rf_v  [NOPS];
    logic [XLEN-1:0] op_v  [NOPS];
    src_sel_e        sel_v [NOPS];

    assign src_v[0] = ex_src_a;
    assign src_v[1] = ex_src_b;
    assign rf_v[0]  = rf_val_a;
    assign rf_v[1]  = rf_val_b;

    bypass_prev_latch #(.XLEN(XLEN), .REGW(REGW)) u_prev (
        .clk      (clk),
        .rst_n    (rst_n),
        .wb_rd    (wb_rd),
        .wb_we    (wb_we),
        .wb_val   (wb_val),
        .prev_rd  (prev_rd),
        .prev_we  (prev_we),
        .prev_val (prev_val)
    );

    for (genvar i = 0; i < NOPS; i++) begin : g_op
        bypass_pick #(.REGW(REGW)) u_pick (
            .src         (src_v[i]),
            .mem_rd      (mem_rd),
            .mem_we      (mem_we),
            .mem_is_load (mem_is_load),
            .wb_rd       (wb_rd),
            .wb_we       (wb_we),
            .prev_rd     (prev_rd),
            .prev_we     (prev_we),
            .sel         (sel_v[i])
        );

        bypass_mux #(.XLEN(XLEN)) u_mux (
            .sel      (sel_v[i]),
            .rf_val   (rf_v[i]),
            .mem_val  (mem_val),
            .wb_val   (wb_val),
            .prev_val (prev_val),
            .op       (op_v[i])
        );

        AST_ZERO_SRC_FROM_RF: assert property (@(posedge clk) disable iff (!rst_n)
            (src_v[i] == '0) |-> (sel_v[i] == SRC_RF && op_v[i] == rf_v[i])); // R6
        AST_MEM_HIT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_we && !mem_is_load && mem_rd == src_v[i] && src_v[i] != '0)
            |-> (op_v[i] == mem_val)); // R5
        AST_LOAD_NOT_BYPASSED: assert property (@(posedge clk) disable iff (!rst_n)
            mem_is_load |-> (sel_v[i] != SRC_MEM)); // R8
        AST_PREV_MATCHES_PAST_WB: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_v[i] == SRC_PREV) |->
            ($past(wb_we) && $past(wb_rd) == src_v[i] && op_v[i] == $past(wb_val))); // R4
        AST_WB_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_v[i] == SRC_WB) |-> (wb_we && op_v[i] == wb_val)); // R7
    end

    AST_NO_PREV_AFTER_RESET: assert property (@(posedge clk)
        $rose(rst_n) |-> (sel_v[0] != SRC_PREV && sel_v[1] != SRC_PREV)); // R10

    assign op_a  = op_v[0];
    assign op_b  = op_v[1];
    assign sel_a = sel_v[0];
    assign sel_b = sel_v[1];

endmodule

// File: tb/opnd_bypass_tb_top.sv
`timescale 1ns/100ps
module opnd_bypass_tb_top;

    localparam int XLEN = 32;
    localparam int REGW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [REGW-1:0] ex_src_a = '0, ex_src_b = '0;
    logic [XLEN-1:0] rf_val_a = '0, rf_val_b = '0;
    logic [REGW-1:0] mem_rd = '0;
    logic            mem_we = 1'b0, mem_is_load = 1'b0;
    logic [XLEN-1:0] mem_val = '0;
    logic [REGW-1:0] wb_rd = '0;
    logic            wb_we = 1'b0;
    logic [XLEN-1:0] wb_val = '0;
    logic [XLEN-1:0] op_a, op_b;
    logic [1:0]      sel_a, sel_b;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    opnd_bypass dut_i (
        .clk(clk), .rst_n(rst_n),
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .rf_val_a(rf_val_a), .rf_val_b(rf_val_b),
        .mem_rd(mem_rd), .mem_we(mem_we), .mem_is_load(mem_is_load), .mem_val(mem_val),
        .wb_rd(wb_rd), .wb_we(wb_we), .wb_val(wb_val),
        .op_a(op_a), .op_b(op_b), .sel_a(sel_a), .sel_b(sel_b)
    );

    task automatic check(input string req, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic settle();
        #0.3;
    endtask

    task automatic clear_producers();
        mem_rd = '0; mem_we = 1'b0; mem_is_load = 1'b0; mem_val = '0;
        wb_rd = '0; wb_we = 1'b0; wb_val = '0;
    endtask

    // Drive a write-back and let the latch capture it, ending at the falling edge.
    task automatic prime_prev(input logic [REGW-1:0] rd, input logic [XLEN-1:0] val);
        @(negedge clk);
        clear_producers();
        wb_rd = rd; wb_we = 1'b1; wb_val = val;
        @(negedge clk);
        clear_producers();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        wb_rd = 5'd5; wb_we = 1'b1; wb_val = 32'hDEAD_0005;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clear_producers();
        ex_src_a = 5'd5; rf_val_a = 32'h0000_0A05;
        ex_src_b = 5'd6; rf_val_b = 32'h0000_0B06;
        settle();
        check("R10 sel_a after reset", sel_a, 0);
        check("R10 op_a after reset", op_a, 32'h0000_0A05);
    endtask

    task automatic t_no_match();
        @(negedge clk);
        clear_producers();
        ex_src_a = 5'd3; rf_val_a = 32'h1111_0003;
        ex_src_b = 5'd4; rf_val_b = 32'h2222_0004;
        mem_rd = 5'd8; mem_we = 1'b1; mem_val = 32'h8888_8888;
        settle();
        check("R1 sel_a", sel_a, 0);
        check("R1 op_a", op_a, 32'h1111_0003);
        check("R1 op_b", op_b, 32'h2222_0004);
    endtask

    task automatic t_dist1();
        @(negedge clk);
        clear_producers();
        ex_src_a = 5'd3; rf_val_a = 32'h1111_0003;
        ex_src_b = 5'd4; rf_val_b = 32'h2222_0004;
        mem_rd = 5'd3; mem_we = 1'b1; mem_val = 32'hA1A1_0001;
        settle();
        check("R2 sel_a", sel_a, 1);
        check("R2 op_a", op_a, 32'hA1A1_0001);
        check("R2 op_b unaffected", op_b, 32'h2222_0004);
    endtask

    task automatic t_dist2();
        @(negedge clk);
        clear_producers();
        ex_src_a = 5'd3; rf_val_a = 32'h1111_0003;
        ex_src_b = 5'd4; rf_val_b = 32'h2222_0004;
        wb_rd = 5'd4; wb_we = 1'b1; wb_val = 32'hB2B2_0002;
        settle();
        check("R3 sel_b", sel_b, 2);
        check("R3 op_b", op_b, 32'hB2B2_0002);
    endtask

    task automatic t_dist3();
        prime_prev(5'd7, 32'hC3C3_0003);
        ex_src_a = 5'd7; rf_val_a = 32'h0000_0777;
        settle();
        check("R4 sel_a", sel_a, 3);
        check("R4 op_a", op_a, 32'hC3C3_0003);
        @(negedge clk);
        settle();
        check("R4 expires after one cycle", op_a, 32'h0000_0777);
    endtask

    task automatic t_priority();
        prime_prev(5'd9, 32'h0000_00A3);
        ex_src_a = 5'd9; rf_val_a = 32'h0000_0909;
        wb_rd = 5'd9; wb_we = 1'b1; wb_val = 32'h0000_00B2;
        mem_rd = 5'd9; mem_we = 1'b1; mem_val = 32'h0000_00C1;
        settle();
        check("R5 mem over wb/prev", op_a, 32'h0000_00C1);
        mem_we = 1'b0;
        settle();
        check("R5 wb over prev", op_a, 32'h0000_00B2);
        wb_we = 1'b0;
        settle();
        check("R5 prev over rf", op_a, 32'h0000_00A3);
    endtask

    task automatic t_zero();
        prime_prev(5'd0, 32'hFFFF_0000);
        ex_src_a = 5'd0; rf_val_a = 32'h0000_0000;
        ex_src_b = 5'd0; rf_val_b = 32'h0000_0000;
        mem_rd = 5'd0; mem_we = 1'b1; mem_val = 32'hEEEE_0000;
        wb_rd = 5'd0; wb_we = 1'b1; wb_val = 32'hDDDD_0000;
        settle();
        check("R6 sel_a", sel_a, 0);
        check("R6 op_a", op_a, 32'h0000_0000);
        check("R6 op_b", op_b, 32'h0000_0000);
    endtask

    task automatic t_wen();
        prime_prev(5'd12, 32'h0);
        // previous cycle had wb_we low via clear_producers after capture
        @(negedge clk);
        ex_src_a = 5'd12; rf_val_a = 32'h0000_0C0C;
        mem_rd = 5'd12; mem_we = 1'b0; mem_val = 32'h1212_1212;
        wb_rd = 5'd12; wb_we = 1'b0; wb_val = 32'h3434_3434;
        settle();
        check("R7 sel_a", sel_a, 0);
        check("R7 op_a", op_a, 32'h0000_0C0C);
    endtask

    task automatic t_load();
        @(negedge clk);
        clear_producers();
        ex_src_a = 5'd3; rf_val_a = 32'h1111_0003;
        mem_rd = 5'd3; mem_we = 1'b1; mem_is_load = 1'b1; mem_val = 32'h5555_AAAA;
        wb_rd = 5'd3; wb_we = 1'b1; wb_val = 32'h6666_0003;
        settle();
        check("R8 falls to wb", op_a, 32'h6666_0003);
        wb_we = 1'b0;
        settle();
        check("R8 falls to rf", op_a, 32'h1111_0003);
    endtask

    task automatic t_mixed();
        prime_prev(5'd20, 32'h2020_2020);
        ex_src_a = 5'd17; rf_val_a = 32'h0;
        ex_src_b = 5'd20; rf_val_b = 32'h0;
        mem_rd = 5'd17; mem_we = 1'b1; mem_val = 32'h1717_1717;
        settle();
        check("R9 sel_a", sel_a, 1);
        check("R9 sel_b", sel_b, 3);
        check("R9 op_a", op_a, 32'h1717_1717);
        check("R9 op_b", op_b, 32'h2020_2020);
    endtask

    initial begin : watchdog
        #200000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        t_reset();
        t_no_match();
        t_dist1();
        t_dist2();
        t_dist3();
        t_priority();
        t_zero();
        t_wen();
        t_load();
        t_mixed();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule